// File: doc/BRIEF.md
# Sequential Integer Divider

This block performs 32-bit integer division over many clock cycles, for a processor pipeline that executes the four division instructions of the multiply/divide extension: signed and unsigned quotient, and signed and unsigned remainder. The pipeline presents both operands and a 2-bit operation code together with a one-cycle start pulse. While the divider works, a busy flag tells the pipeline to hold the instruction in place. When the operation ends, a one-cycle done strobe marks the result as valid.

The datapath is a restoring shift-and-subtract loop that produces one quotient bit per clock cycle. Each step compares the partial remainder against the divisor magnitude and subtracts only when the remainder is not smaller. For signed operations, the divider first converts both operands to magnitudes. After the last step it corrects the signs: the quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. Division by zero and signed overflow return the results the instruction set defines.

Top module: `int_div_seq`

## Requirements
- R1: `op_i` selects the operation: bit 0 set means unsigned, clear means signed; bit 1 set returns the remainder, clear returns the quotient (00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder). An unsigned quotient equals floor(dividend / divisor).
- R2: A signed quotient is truncated toward zero. It is negative exactly when the operand signs differ and the true quotient is non-zero.
- R3: A remainder satisfies dividend = quotient*divisor + remainder. Its magnitude is below the divisor magnitude, and for signed operation it has the sign of the dividend.
- R4: With a zero divisor, the quotient is all ones for both signed and unsigned operation, and the remainder equals the dividend.
- R5: Signed division of 0x80000000 by 0xFFFFFFFF returns the dividend as the quotient and zero as the remainder.
- R6: A start that is accepted on a clock edge sets `busy_o` from that edge on for 32 cycles. On the 32nd edge after the start edge, `busy_o` falls and `done_o` is high for exactly one cycle with the result.
- R7: A start pulse that arrives while `busy_o` is high is ignored. The operation in progress finishes on schedule and returns its own result.
- R8: After reset, `busy_o` and `done_o` are low and `result_o` is zero. `result_o` keeps its last value until the next operation completes.
- R9: A start pulse in the cycle where `done_o` is high is accepted. This lets operations run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when not busy |
| op_i | input | 2 | Operation code (bit 0 unsigned, bit 1 remainder) |
| dividend_i | input | 32 | Dividend, sampled with start |
| divisor_i | input | 32 | Divisor, sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle strobe; result valid |
| result_o | output | 32 | Quotient or remainder, held until the next completion |

## Verification
Small positive operands are run under each of the four operation codes. This separates quotient from remainder selection and signed from unsigned handling. Every sign combination of signed operands shows whether the quotient truncates toward zero and whether the remainder follows the dividend's sign. Zero divisors (with positive and negative dividends) and the single overflow pair probe the special-case paths, and operands with the top bit set separate the unsigned interpretation from the signed one. A start pulse issued mid-operation, and another issued in the done cycle, test start acceptance; random operand pairs fill in the rest.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    OP_DIV  = 2'b00,
    OP_DIVU = 2'b01,
    OP_REM  = 2'b10,
    OP_REMU = 2'b11
  } div_op_e;

  localparam int unsigned UNS_BIT = 0;
  localparam int unsigned REM_BIT = 1;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] dvd_mag_o,
  output logic [WIDTH-1:0] dvs_mag_o,
  output logic             neg_quo_o,
  output logic             neg_rem_o
);
  import div_pkg::*;

  logic is_signed, sgn_a, sgn_b, dvs_zero;

  assign is_signed = ~op_i[UNS_BIT];
  assign sgn_a     = is_signed & dividend_i[WIDTH-1];
  assign sgn_b     = is_signed & divisor_i[WIDTH-1];
  assign dvs_zero  = (divisor_i == '0);

  assign dvd_mag_o = sgn_a ? (~dividend_i + 1'b1) : dividend_i;
  assign dvs_mag_o = sgn_b ? (~divisor_i + 1'b1) : divisor_i;

  // zero divisor keeps the all-ones quotient unsigned
  assign neg_quo_o = (sgn_a ^ sgn_b) & ~dvs_zero;
  assign neg_rem_o = sgn_a;
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [WIDTH-1:0] rem_o,
  output logic [WIDTH-1:0] quo_o
);
  logic [WIDTH:0] trial;
  logic [WIDTH:0] diff;
  logic           fits;

  assign trial = {rem_i, quo_i[WIDTH-1]};
  assign fits  = (trial >= {1'b0, dvs_i});
  assign diff  = trial - {1'b0, dvs_i};

  assign rem_o = fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
  assign quo_o = {quo_i[WIDTH-2:0], fits};
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic             neg_quo_i,
  input  logic             neg_rem_i,
  input  logic             want_rem_i,
  output logic [WIDTH-1:0] result_o
);
  logic [WIDTH-1:0] quo_s, rem_s;

  assign quo_s    = neg_quo_i ? (~quo_i + 1'b1) : quo_i;
  assign rem_s    = neg_rem_i ? (~rem_i + 1'b1) : rem_i;
  assign result_o = want_rem_i ? rem_s : quo_s;
endmodule

// File: rtl/int_div_seq.sv
module int_div_seq
  import div_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int unsigned CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] rem_q, quo_q, dvs_q, result_q;
  logic             neg_quo_q, neg_rem_q, want_rem_q;

  logic [WIDTH-1:0] dvd_mag, dvs_mag, step_rem, step_quo, fix_res;
  logic             neg_quo, neg_rem, accept;

  assign accept = start_i & ~busy_q;

  div_prep #(.WIDTH(WIDTH)) u_prep (
    .op_i      (op_i),
    .dividend_i(dividend_i),
    .divisor_i (divisor_i),
    .dvd_mag_o (dvd_mag),
    .dvs_mag_o (dvs_mag),
    .neg_quo_o (neg_quo),
    .neg_rem_o (neg_rem)
  );

  div_step #(.WIDTH(WIDTH)) u_step (
    .rem_i(rem_q),
    .quo_i(quo_q),
    .dvs_i(dvs_q),
    .rem_o(step_rem),
    .quo_o(step_quo)
  );

  div_fix #(.WIDTH(WIDTH)) u_fix (
    .rem_i     (step_rem),
    .quo_i     (step_quo),
    .neg_quo_i (neg_quo_q),
    .neg_rem_i (neg_rem_q),
    .want_rem_i(want_rem_q),
    .result_o  (fix_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      cnt_q      <= '0;
      rem_q      <= '0;
      quo_q      <= '0;
      dvs_q      <= '0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      want_rem_q <= 1'b0;
      result_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q     <= 1'b1;
        cnt_q      <= '0;
        rem_q      <= '0;
        quo_q      <= dvd_mag;
        dvs_q      <= dvs_mag;
        neg_quo_q  <= neg_quo;
        neg_rem_q  <= neg_rem;
        want_rem_q <= op_i[REM_BIT];
      end else if (busy_q) begin
        rem_q <= step_rem;
        quo_q <= step_quo;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= fix_res;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = result_q;

  a_r6_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r6_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r6_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r7_busy_keeps_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != LAST) |=> ($stable(dvs_q) && $stable(want_rem_q) && busy_q));
  a_r3_rem_below_dvs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && dvs_q != '0) |-> (rem_q < dvs_q));
  a_r8_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || $stable(result_o)));
endmodule

// File: tb/int_div_seq_bench.sv
module int_div_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] res;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R8";

  bit          m_busy = 1'b0, m_done = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_res = '0, m_pend = '0;

  always #10 clk = ~clk;

  int_div_seq u_int_div_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .dividend_i(a), .divisor_i(b),
    .busy_o(busy), .done_o(done), .result_o(res)
  );

  function automatic logic [31:0] ref_div(logic [1:0] o, logic [31:0] x, logic [31:0] y);
    longint sx, sy;
    bit is_rem, uns;
    is_rem = o[1];
    uns    = o[0];
    if (y == 0) return is_rem ? x : 32'hFFFF_FFFF;
    if (uns) return is_rem ? (x % y) : (x / y);
    if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return is_rem ? 32'h0 : x;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    return is_rem ? 32'(sx % sy) : 32'(sx / sy);
  endfunction

  // behavioural timing model: 32 busy edges after the accepting edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 32) begin
          m_busy = 1'b0; m_done = 1'b1; m_res = m_pend;
        end
      end else if (start) begin
        m_busy = 1'b1; m_cnt = 0; m_pend = ref_div(op, a, b);
      end
    end
  end

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(busy == m_busy, "R6 busy", 32'(busy), 32'(m_busy));
    chk(done == m_done, "R6 done", 32'(done), 32'(m_done));
    chk(res == m_res, "result", res, m_res);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic issue(logic [1:0] o, logic [31:0] x, logic [31:0] y);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(string t, logic [1:0] o, logic [31:0] x, logic [31:0] y);
    tag = t;
    issue(o, x, y);
    repeat (33) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run("R1", 2'b01, 32'd100, 32'd7);
    run("R1", 2'b01, 32'hFFFF_FFFF, 32'd3);
    run("R1", 2'b01, 32'h8000_0000, 32'hFFFF_FFFF);
    run("R1", 2'b01, 32'd5, 32'd9);
    run("R1", 2'b11, 32'hFFFF_FFFF, 32'd10);
    run("R2", 2'b00, -32'sd100, 32'd7);
    run("R2", 2'b00, 32'd100, -32'sd7);
    run("R2", 2'b00, -32'sd100, -32'sd7);
    run("R2", 2'b00, 32'd7, 32'd100);
    run("R3", 2'b10, -32'sd100, 32'd7);
    run("R3", 2'b10, 32'd100, -32'sd7);
    run("R3", 2'b10, -32'sd100, -32'sd7);
    run("R4", 2'b00, -32'sd5, 32'd0);
    run("R4", 2'b01, 32'd5, 32'd0);
    run("R4", 2'b10, -32'sd5, 32'd0);
    run("R4", 2'b11, 32'd9, 32'd0);
    run("R5", 2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
    run("R5", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);

    // R7: start mid-operation must not disturb the running one
    tag = "R7";
    issue(2'b00, 32'd1000, 32'd3);
    repeat (5) @(negedge clk);
    start = 1'b1; op = 2'b11; a = 32'd77; b = 32'd5;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);

    // R9: start in the done cycle
    tag = "R9";
    issue(2'b01, 32'd81, 32'd9);
    while (!done) @(negedge clk);
    start = 1'b1; op = 2'b10; a = -32'sd81; b = 32'd4;
    @(negedge clk);
    start = 1'b0;
    repeat (34) @(negedge clk);

    for (int i = 0; i < 40; i++) begin
      run("R2", 2'($urandom), $urandom, (i % 4 == 0) ? 32'($urandom % 16) : $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule